// File: doc/BRIEF.md
# Synchronous Decade Divider with Retimed One-Second Pulse

This block turns a stable reference oscillator into a once-per-second timing pulse. A chain of cascaded decade counters, each a five-flop twisted-ring (Johnson) counter with ten decodable states, divides the oscillator clock. Every stage runs on the oscillator clock itself and advances only when all the stages below it are at their terminal state. The whole chain is therefore synchronous and has no ripple delay.

When the chain wraps, the block raises an internal pulse. A two-flop retimer on the oscillator clock then shifts that pulse out, so the output edge comes a fixed number of oscillator cycles after the chain reaches its terminal count. A mode pin selects a 10 MHz or a 5 MHz reference. In 5 MHz mode the lowest stage is short-cycled to count five states, so the overall ratio halves. A separate binary tap gives the oscillator divided by 256, for use by a disciplining loop. Reset is synchronous and puts every stage into its zero state. This lets the chain be phase-aligned to an external event.

Top module: `decade_pps_divider`

## Requirements
- R1: After a clock edge that samples `rst_n` low, `pps_o` and `tap_o` are low, and every stage of the chain is in its all-zeros code.
- R2: Each stage is a `STAGE_BITS`-wide Johnson counter. It holds only its 2*`STAGE_BITS` legal codes, and it changes state only in a cycle in which every lower stage is at its terminal code.
- R3: With `mode_5m` low, the chain wraps once every 10^`NUM_DECADES` oscillator cycles, so `pps_o` rises with exactly that period.
- R4: Each output pulse stays high for one full cycle of the lowest stage's carry. That is 10 oscillator cycles with `mode_5m` low and 5 with `mode_5m` high.
- R5: With `mode_5m` high, the lowest stage returns from code 01111 to 00000 and counts five states. The period becomes 5*10^(`NUM_DECADES`-1) oscillator cycles.
- R6: `tap_o` is a square wave with a period of 2^`TAP_BITS` cycles. After n clock edges since reset, it is high exactly when (n mod 2^`TAP_BITS`) is at least 2^(`TAP_BITS`-1).
- R7: With D the period, `pps_o` first rises after clock edge D+2 counted from reset release. That is two retimer cycles after the edge that follows the chain's terminal count, and the same offset holds in every later period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; every flop of the block runs on it |
| rst_n | input | 1 | Synchronous active-low reset and phase-align control |
| mode_5m | input | 1 | 0: 10 MHz reference, 1: 5 MHz reference; change it only while in reset |
| pps_o | output | 1 | Retimed once-per-period pulse |
| tap_o | output | 1 | Oscillator divided by 2^TAP_BITS, square wave |

## Verification
The divider runs from reset in 10 MHz mode for more than two periods, so the bench can tell a correct period from one that is off by a cycle and a two-flop delay from a one- or three-flop delay. Reset is then applied in the middle of an output pulse. This shows that the chain, the shaper and the retimer all restart from zero together, not from stale state. Last, 5 MHz mode runs over several periods. This tells a short-cycled first stage apart from a full decade, and a five-cycle pulse apart from a ten-cycle one. The tap is compared on every cycle throughout, across many of its 256-cycle periods.

// File: rtl/pps_div_pkg.sv
package pps_div_pkg;

  // Next code of a twisted-ring counter: shift left, feed back inverted MSB.
  function automatic logic [15:0] johnson_step(input logic [15:0] q, input int bits);
    logic [15:0] r;
    r = '0;
    for (int k = bits - 1; k > 0; k--) r[k] = q[k-1];
    r[0] = ~q[bits-1];
    return r;
  endfunction

  // A legal code is a run of ones from bit 0, or the complement of one.
  function automatic logic johnson_legal(input logic [15:0] q, input int bits);
    logic [15:0] mask;
    logic [15:0] v;
    logic [15:0] nv;
    mask = (16'd1 << bits) - 16'd1;
    v    = q & mask;
    nv   = ~q & mask;
    return ((v & (v + 16'd1)) == 16'd0) || ((nv & (nv + 16'd1)) == 16'd0);
  endfunction

endpackage

// File: rtl/johnson_stage.sv
module johnson_stage #(
  parameter int STAGE_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_i,
  input  logic                  short_i,
  output logic [STAGE_BITS-1:0] q_o,
  output logic                  term_o
);
  import pps_div_pkg::*;

  logic [STAGE_BITS-1:0] q;
  logic [15:0]           q_wide;
  logic [15:0]           step_wide;
  logic                  term_full;
  logic                  term_half;

  assign q_wide    = 16'(q);
  assign step_wide = johnson_step(q_wide, STAGE_BITS);

  // Terminal code for the full count is 100..0, for the half count 011..1.
  assign term_full = q[STAGE_BITS-1] & ~q[STAGE_BITS-2];
  assign term_half = ~q[STAGE_BITS-1] & q[STAGE_BITS-2];
  assign term_o    = short_i ? term_half : term_full;

  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (adv_i && term_o) q <= '0;
    else if (adv_i)           q <= step_wide[STAGE_BITS-1:0];
  end

  assign q_o = q;
endmodule

// File: rtl/pps_retimer.sv
module pps_retimer #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], d_i};
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/tap_counter.sv
module tap_counter #(
  parameter int TAP_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tap_o
);
  logic [TAP_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tap_o = cnt[TAP_BITS-1];
endmodule

// File: rtl/decade_pps_divider.sv
module decade_pps_divider #(
  parameter int NUM_DECADES = 7,
  parameter int STAGE_BITS  = 5,
  parameter int TAP_BITS    = 8,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_5m,
  output logic pps_o,
  output logic tap_o
);
  localparam int LAST = NUM_DECADES - 1;

  logic [NUM_DECADES-1:0][STAGE_BITS-1:0] stage_q;
  logic [NUM_DECADES-1:0]                 stage_term;
  logic [NUM_DECADES:0]                   carry;
  logic                                   chain_wrap;
  logic                                   first_carry;
  logic                                   raw_pps;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_stage
    logic short_sel;
    if (i == 0) begin : g_first
      assign short_sel = mode_5m;
    end else begin : g_upper
      assign short_sel = 1'b0;
    end

    johnson_stage #(.STAGE_BITS(STAGE_BITS)) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (carry[i]),
      .short_i (short_sel),
      .q_o     (stage_q[i]),
      .term_o  (stage_term[i])
    );

    assign carry[i+1] = carry[i] & stage_term[i];
  end

  assign chain_wrap  = carry[LAST+1];
  assign first_carry = carry[1];

  // Pulse shaper: set on chain wrap, cleared at the next lowest-stage carry.
  always_ff @(posedge clk) begin
    if (!rst_n)           raw_pps <= 1'b0;
    else if (chain_wrap)  raw_pps <= 1'b1;
    else if (first_carry) raw_pps <= 1'b0;
  end

  pps_retimer #(.DEPTH(SYNC_DEPTH)) retime_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_pps),
    .q_o   (pps_o)
  );

  tap_counter #(.TAP_BITS(TAP_BITS)) tap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (tap_o)
  );
endmodule

// File: rtl/decade_pps_divider_chk.sv
module decade_pps_divider_chk #(
  parameter int NUM_DECADES = 7,
  parameter int STAGE_BITS  = 5
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   mode_5m,
  input logic                                   pps_o,
  input logic                                   tap_o,
  input logic                                   raw_pps,
  input logic                                   chain_wrap,
  input logic [NUM_DECADES:0]                   carry,
  input logic [NUM_DECADES-1:0][STAGE_BITS-1:0] stage_q
);
  import pps_div_pkg::*;

  localparam logic [STAGE_BITS-1:0] HALF_CODE = {1'b0, {(STAGE_BITS-1){1'b1}}};

  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (pps_o) hi_cnt <= hi_cnt + 8'd1;
    else            hi_cnt <= '0;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!pps_o && !tap_o && stage_q == '0));

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_stage_chk
    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      johnson_legal(16'(stage_q[i]), STAGE_BITS));
    assert_hold_without_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !carry[i] |=> $stable(stage_q[i]));
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pps_o) |-> (hi_cnt == (mode_5m ? 8'(STAGE_BITS) : 8'(2*STAGE_BITS))));

  assert_short_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_5m && stage_q[0] == HALF_CODE) |=> stage_q[0] == '0);

  assert_wrap_sets_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_wrap |=> raw_pps);

  assert_retime_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_pps) |=> ##1 $rose(pps_o));
endmodule

bind decade_pps_divider decade_pps_divider_chk #(
  .NUM_DECADES (NUM_DECADES),
  .STAGE_BITS  (STAGE_BITS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_5m    (mode_5m),
  .pps_o      (pps_o),
  .tap_o      (tap_o),
  .raw_pps    (raw_pps),
  .chain_wrap (chain_wrap),
  .carry      (carry),
  .stage_q    (stage_q)
);

// File: tb/decade_pps_divider_tb_top.sv
module decade_pps_divider_tb_top;
  localparam int N_DEC  = 3;
  localparam int SBITS  = 5;
  localparam int TBITS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_5m = 1'b0;
  logic pps_o;
  logic tap_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_edges = 0;
  bit m_in_reset = 1'b1;
  bit m_mode = 1'b0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_pps_divider #(
    .NUM_DECADES (N_DEC),
    .STAGE_BITS  (SBITS),
    .TAP_BITS    (TBITS)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_5m (mode_5m),
    .pps_o   (pps_o),
    .tap_o   (tap_o)
  );

  // Behavioural reference: edges counted since reset release.
  always @(posedge clk) begin
    m_mode <= mode_5m;
    if (!rst_n) begin
      n_edges    <= 0;
      m_in_reset <= 1'b1;
    end else begin
      n_edges    <= n_edges + 1;
      m_in_reset <= 1'b0;
    end
  end

  function automatic int first_mod(input bit m5);
    return m5 ? SBITS : 2 * SBITS;
  endfunction

  function automatic int period(input bit m5);
    int p;
    p = first_mod(m5);
    for (int k = 1; k < N_DEC; k++) p = p * (2 * SBITS);
    return p;
  endfunction

  task automatic compare(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %b expected %b", tag, n_edges, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      int d;
      int m0;
      int ph;
      logic e_pps;
      logic e_tap;
      string tag;
      d  = period(m_mode);
      m0 = first_mod(m_mode);
      ph = n_edges - 2;
      e_tap = ((n_edges % (1 << TBITS)) >= (1 << (TBITS - 1)));
      e_pps = (n_edges >= d + 2) && ((ph % d) < m0);
      if (m_in_reset) tag = "R1";
      else if (e_pps && (ph % d) == 0) tag = "R7";
      else if (e_pps) tag = "R4";
      else if (m_mode) tag = "R5";
      else tag = "R2/R3";
      compare(tag, pps_o, e_pps);
      compare(m_in_reset ? "R1" : "R6", tap_o, e_tap);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 R2 R3 R4 R6 R7: 10 MHz mode from reset, several periods
    @(negedge clk);
    rst_n = 1'b0; mode_5m = 1'b0;
    @(negedge clk);
    chk_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2005) @(negedge clk);
    // R1: reset in the middle of an output pulse
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2400) @(negedge clk);
    // R5 R4: 5 MHz mode, entered through reset
    rst_n = 1'b0; mode_5m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (1800) @(negedge clk);
    // Back to 10 MHz to confirm the full decade returns
    rst_n = 1'b0; mode_5m = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (1100) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule